// File: doc/BRIEF.md
# Acknowledge-Polling Sequencer for Two-Wire Serial Memories

After a write to a serial memory, the memory spends some time committing the data and ignores the bus while it does so. This sequencer finds out when that internal cycle has ended. It keeps probing the memory: each probe is a START condition followed by the device select byte with the direction bit at 0. Probes repeat until the memory acknowledges one of them. The sequencer then keeps that acknowledged select and goes on with the next transfer. It sends the memory byte address, most significant byte first. After that it either leaves the bus held so the user can stream write data, or it issues a repeated START and a read select so a random-address read can follow.

The block does not generate bus waveforms itself. It drives a byte-level command port on a bit engine. Four operations are encoded on `cmdOp`: START = 0, WRITE (send `cmdData`, report the acknowledge) = 1, STOP = 2, repeated START = 3. Only one command is in flight at a time. A command is presented with `cmdValid` and held until the engine pulses `cmdDone`. For a WRITE, the engine reports the acknowledge on `cmdAck` in that same cycle.

The user sets a limit on the number of probes. Between refused probes the sequencer can send a STOP, or it can go straight to the next START. A successful probe gives a one-cycle completion pulse and an attempt count. Running out of probes closes the bus with a STOP and raises an error flag.

Top module: `ackpoll_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `cmdValid`, `pollDone` and `timeoutErr` are 0 and `attemptCount` is 0.
- R2: Every probe is a START (op 0) and then a WRITE (op 1) of the select byte `{devAddr, 1'b0}`.
- R3: After a probe is refused (`cmdAck` = 0) and the limit is not reached, the next probe follows. If `stopBetween` is 1, a STOP (op 2) is sent before it. If `stopBetween` is 0, the next START follows directly.
- R4: When a probe is acknowledged, `pollDone` is high for exactly one cycle, in the cycle after the `cmdDone`. `attemptCount` then equals the number of select bytes sent, counting the acknowledged one.
- R5: After the acknowledged probe, the `byteAddr` bytes are sent as WRITEs, most significant byte first. If `readNext` is 0, the block then returns to idle without sending a STOP.
- R6: If `readNext` is 1, the address bytes are followed by a repeated START (op 3) and a WRITE of `{devAddr, 1'b1}`, and then the block returns to idle.
- R7: A probe is refused when the number of probes sent has reached `maxAttempts` (0 counts as 1). The block then sends a STOP, sets `timeoutErr` and gives no `pollDone`. `timeoutErr` stays set until the next accepted `startPoll`.
- R8: All inputs are latched when `startPoll` is accepted. Changes to them, and further `startPoll` pulses, have no effect while `busy` is 1.
- R9: While `cmdValid` is high and `cmdDone` has not come, `cmdValid`, `cmdOp` and `cmdData` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startPoll | input | 1 | Start a polling run (taken only when idle) |
| devAddr | input | 7 | Device address of the memory |
| byteAddr | input | 8*ADDR_BYTES | Memory byte address for the next transfer |
| readNext | input | 1 | 1: follow with a random-address read; 0: follow with a write |
| maxAttempts | input | CNT_W | Probe limit (0 treated as 1) |
| stopBetween | input | 1 | Send a STOP between refused probes |
| cmdValid | output | 1 | Command presented to the bit engine |
| cmdOp | output | 2 | Command: 0 START, 1 WRITE, 2 STOP, 3 repeated START |
| cmdData | output | 8 | Byte sent for a WRITE |
| cmdDone | input | 1 | Bit engine finished the current command |
| cmdAck | input | 1 | Acknowledge seen for a WRITE, valid with `cmdDone` |
| busy | output | 1 | A polling run is in progress |
| pollDone | output | 1 | One-cycle pulse: the memory acknowledged a probe |
| timeoutErr | output | 1 | The probe limit ran out in the last run |
| attemptCount | output | CNT_W | Number of select bytes sent in the current or last run |

## Verification
Every result lands at a fixed distance from the engine's `cmdDone`. The next command appears on the command port in the cycle after each `cmdDone`. `pollDone` and the updated `attemptCount` appear in the cycle after the acknowledged select's `cmdDone`. `timeoutErr` rises in the cycle after the closing STOP's `cmdDone`. The bench's engine model raises `cmdDone` on a falling edge and reads the next command on the following falling edge. It samples `pollDone` and `attemptCount` on falling edges, and it checks final state several cycles after `busy` falls. The engine delay varies between 0 and 3 cycles across the vectors, so no check assumes a particular engine delay.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

  typedef enum logic [1:0] {
    OP_START   = 2'd0,
    OP_WRITE   = 2'd1,
    OP_STOP    = 2'd2,
    OP_RESTART = 2'd3
  } cmdOp_e;

  typedef enum logic [1:0] {
    BYTE_SELW = 2'd0,
    BYTE_ADDR = 2'd1,
    BYTE_SELR = 2'd2
  } byteSel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_SEL, ST_GAP, ST_FAIL, ST_ADDR, ST_RST, ST_RSEL
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     loadCfg;
    logic     incCnt;
    logic     ackSeen;
    logic     shiftAddr;
    logic     setErr;
    byteSel_e byteSel;
  } strobe_t;

endpackage

// File: rtl/ackpoll_ctrl.sv
module ackpoll_ctrl
  import ackpoll_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    startPoll,
  input  logic    cmdDone,
  input  logic    cmdAck,
  input  logic    lastAttempt,
  input  logic    lastAddrByte,
  input  logic    readNextQ,
  input  logic    stopBetweenQ,
  output logic    cmdValid,
  output cmdOp_e  cmdOp,
  output strobe_t stb,
  output logic    busy
);

  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    nxt         = state;
    stb         = '0;
    stb.byteSel = BYTE_SELW;
    cmdValid    = 1'b1;
    cmdOp       = OP_WRITE;
    case (state)
      ST_IDLE: begin
        cmdValid = 1'b0;
        if (startPoll) begin
          stb.loadCfg = 1'b1;
          nxt         = ST_START;
        end
      end
      ST_START: begin
        cmdOp = OP_START;
        if (cmdDone) nxt = ST_SEL;
      end
      ST_SEL: begin
        stb.byteSel = BYTE_SELW;
        if (cmdDone) begin
          stb.incCnt = 1'b1;
          if (cmdAck) begin
            stb.ackSeen = 1'b1;
            nxt         = ST_ADDR;
          end else if (lastAttempt) begin
            nxt = ST_FAIL;
          end else if (stopBetweenQ) begin
            nxt = ST_GAP;
          end else begin
            nxt = ST_START;
          end
        end
      end
      ST_GAP: begin
        cmdOp = OP_STOP;
        if (cmdDone) nxt = ST_START;
      end
      ST_FAIL: begin
        cmdOp = OP_STOP;
        if (cmdDone) begin
          stb.setErr = 1'b1;
          nxt        = ST_IDLE;
        end
      end
      ST_ADDR: begin
        stb.byteSel = BYTE_ADDR;
        if (cmdDone) begin
          stb.shiftAddr = 1'b1;
          if (lastAddrByte) nxt = readNextQ ? ST_RST : ST_IDLE;
        end
      end
      ST_RST: begin
        cmdOp = OP_RESTART;
        if (cmdDone) nxt = ST_RSEL;
      end
      ST_RSEL: begin
        stb.byteSel = BYTE_SELR;
        if (cmdDone) nxt = ST_IDLE;
      end
      default: begin
        cmdValid = 1'b0;
        nxt      = ST_IDLE;
      end
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/ackpoll_dp.sv
module ackpoll_dp
  import ackpoll_pkg::*;
#(
  parameter  int ADDR_BYTES = 2,
  parameter  int CNT_W      = 8,
  localparam int ADDR_W     = 8 * ADDR_BYTES,
  localparam int IDX_W      = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [6:0]        devAddr,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic              readNext,
  input  logic              stopBetween,
  input  logic [CNT_W-1:0]  maxAttempts,
  output logic [7:0]        cmdData,
  output logic              lastAttempt,
  output logic              lastAddrByte,
  output logic              readNextQ,
  output logic              stopBetweenQ,
  output logic              pollDone,
  output logic              timeoutErr,
  output logic [CNT_W-1:0]  attemptCount
);

  logic [6:0]        devQ;
  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  maxQ;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic              errQ;
  logic              doneQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      devQ         <= '0;
      addrQ        <= '0;
      maxQ         <= '0;
      readNextQ    <= 1'b0;
      stopBetweenQ <= 1'b0;
      cnt          <= '0;
      idx          <= '0;
      errQ         <= 1'b0;
      doneQ        <= 1'b0;
    end else begin
      doneQ <= stb.ackSeen;
      if (stb.loadCfg) begin
        devQ         <= devAddr;
        addrQ        <= byteAddr;
        maxQ         <= maxAttempts;
        readNextQ    <= readNext;
        stopBetweenQ <= stopBetween;
        cnt          <= '0;
        idx          <= '0;
        errQ         <= 1'b0;
      end
      if (stb.incCnt) cnt <= cnt + 1'b1;
      if (stb.shiftAddr) begin
        addrQ <= addrQ << 8;
        idx   <= idx + 1'b1;
      end
      if (stb.setErr) errQ <= 1'b1;
    end
  end

  // the probe now in flight is the last one allowed (limit 0 acts as 1)
  assign lastAttempt  = ((CNT_W+1)'(cnt) + 1'b1) >= (CNT_W+1)'(maxQ);
  assign lastAddrByte = (idx == IDX_W'(ADDR_BYTES - 1));

  always_comb begin
    case (stb.byteSel)
      BYTE_ADDR: cmdData = addrQ[ADDR_W-1 -: 8];
      BYTE_SELR: cmdData = {devQ, 1'b1};
      default:   cmdData = {devQ, 1'b0};
    endcase
  end

  assign pollDone     = doneQ;
  assign timeoutErr   = errQ;
  assign attemptCount = cnt;

endmodule

// File: rtl/ackpoll_seq.sv
module ackpoll_seq
  import ackpoll_pkg::*;
#(
  parameter  int ADDR_BYTES = 2,
  parameter  int CNT_W      = 8,
  localparam int ADDR_W     = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startPoll,
  input  logic [6:0]        devAddr,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic              readNext,
  input  logic [CNT_W-1:0]  maxAttempts,
  input  logic              stopBetween,
  output logic              cmdValid,
  output logic [1:0]        cmdOp,
  output logic [7:0]        cmdData,
  input  logic              cmdDone,
  input  logic              cmdAck,
  output logic              busy,
  output logic              pollDone,
  output logic              timeoutErr,
  output logic [CNT_W-1:0]  attemptCount
);

  strobe_t stb;
  cmdOp_e  opE;
  logic    lastAttempt, lastAddrByte, readNextQ, stopBetweenQ;

  ackpoll_ctrl ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .startPoll    (startPoll),
    .cmdDone      (cmdDone),
    .cmdAck       (cmdAck),
    .lastAttempt  (lastAttempt),
    .lastAddrByte (lastAddrByte),
    .readNextQ    (readNextQ),
    .stopBetweenQ (stopBetweenQ),
    .cmdValid     (cmdValid),
    .cmdOp        (opE),
    .stb          (stb),
    .busy         (busy)
  );

  ackpoll_dp #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) dp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .stb          (stb),
    .devAddr      (devAddr),
    .byteAddr     (byteAddr),
    .readNext     (readNext),
    .stopBetween  (stopBetween),
    .maxAttempts  (maxAttempts),
    .cmdData      (cmdData),
    .lastAttempt  (lastAttempt),
    .lastAddrByte (lastAddrByte),
    .readNextQ    (readNextQ),
    .stopBetweenQ (stopBetweenQ),
    .pollDone     (pollDone),
    .timeoutErr   (timeoutErr),
    .attemptCount (attemptCount)
  );

  assign cmdOp = opE;

endmodule

// File: rtl/ackpoll_chk.sv
module ackpoll_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmdValid,
  input logic [1:0]       cmdOp,
  input logic [7:0]       cmdData,
  input logic             cmdDone,
  input logic             cmdAck,
  input logic             busy,
  input logic             pollDone,
  input logic             timeoutErr,
  input logic [CNT_W-1:0] attemptCount
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmdValid);

  p_done_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pollDone |-> $past(cmdDone && cmdAck && cmdOp == 2'd1));

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pollDone |=> !pollDone);

  p_done_counted_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pollDone |-> attemptCount != '0);

  p_err_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeoutErr) |-> $past(cmdDone && cmdOp == 2'd2));

  p_err_no_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timeoutErr |-> !pollDone);

  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && !cmdDone) |=> (cmdValid && $stable(cmdOp) && $stable(cmdData)));

endmodule

bind ackpoll_seq ackpoll_chk #(.CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmdValid     (cmdValid),
  .cmdOp        (cmdOp),
  .cmdData      (cmdData),
  .cmdDone      (cmdDone),
  .cmdAck       (cmdAck),
  .busy         (busy),
  .pollDone     (pollDone),
  .timeoutErr   (timeoutErr),
  .attemptCount (attemptCount)
);

// File: tb/ackpoll_seq_tb_top.sv
module ackpoll_seq_tb_top;

  typedef struct packed {
    logic [7:0]  nacks;
    logic [7:0]  maxAtt;
    logic        sb;
    logic        rd;
    logic [1:0]  lat;
    logic [6:0]  dev;
    logic [15:0] addr;
    logic        expErr;
    logic [7:0]  expAtt;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'd0, 8'd5, 1'b0, 1'b0, 2'd1, 7'h50, 16'h1234, 1'b0, 8'd1},
    '{8'd3, 8'd8, 1'b1, 1'b0, 2'd2, 7'h50, 16'hABCD, 1'b0, 8'd4},
    '{8'd2, 8'd8, 1'b0, 1'b1, 2'd0, 7'h21, 16'h00FF, 1'b0, 8'd3},
    '{8'd4, 8'd4, 1'b1, 1'b0, 2'd1, 7'h50, 16'h0F0F, 1'b1, 8'd4},
    '{8'd3, 8'd4, 1'b0, 1'b1, 2'd3, 7'h7F, 16'hFF00, 1'b0, 8'd4},
    '{8'd9, 8'd0, 1'b1, 1'b0, 2'd1, 7'h01, 16'h8001, 1'b1, 8'd1},
    '{8'd0, 8'd1, 1'b0, 1'b1, 2'd2, 7'h33, 16'h5A5A, 1'b0, 8'd1},
    '{8'd6, 8'd3, 1'b0, 1'b0, 2'd0, 7'h44, 16'h0001, 1'b1, 8'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startPoll = 1'b0;
  logic [6:0]  devAddr = '0;
  logic [15:0] byteAddr = '0;
  logic        readNext = 1'b0;
  logic [7:0]  maxAttempts = '0;
  logic        stopBetween = 1'b0;
  logic        cmdValid;
  logic [1:0]  cmdOp;
  logic [7:0]  cmdData;
  logic        cmdDone = 1'b0;
  logic        cmdAck = 1'b0;
  logic        busy, pollDone, timeoutErr;
  logic [7:0]  attemptCount;

  ackpoll_seq #(.ADDR_BYTES(2), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .startPoll(startPoll), .devAddr(devAddr),
    .byteAddr(byteAddr), .readNext(readNext), .maxAttempts(maxAttempts),
    .stopBetween(stopBetween), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .cmdDone(cmdDone), .cmdAck(cmdAck), .busy(busy),
    .pollDone(pollDone), .timeoutErr(timeoutErr), .attemptCount(attemptCount)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  int lat = 1;
  int nackLeft = 0;
  int stableErr = 0;
  int pdCount = 0;
  int pdAtt = 0;
  int logN = 0;
  int expN = 0;
  logic [1:0] prevOp = 2'd2;
  logic [9:0] logArr [64];
  logic [9:0] expArr [64];

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        chk(1'b0, "watchdog", cycles, 100000);
        finishRun();
      end
    end
  end

  // bit-engine model: one command at a time, done after lat cycles
  initial begin
    logic [1:0] op;
    logic [7:0] dat;
    logic       ackv;
    forever begin
      @(negedge clk);
      cmdDone = 1'b0;
      cmdAck  = 1'b0;
      if (rst_n && cmdValid) begin
        op  = cmdOp;
        dat = cmdData;
        if (logN < 64) logArr[logN] = {op, (op == 2'd1) ? dat : 8'h00};
        logN++;
        ackv = 1'b1;
        if (op == 2'd1 && prevOp == 2'd0 && nackLeft > 0) begin
          ackv = 1'b0;
          nackLeft--;
        end
        prevOp = op;
        for (int w = 0; w < lat; w++) begin
          @(negedge clk);
          if (rst_n && (!cmdValid || cmdOp != op || cmdData != dat)) stableErr++;
        end
        cmdDone = 1'b1;
        cmdAck  = ackv;
      end
    end
  end

  // completion monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && pollDone) begin
        pdCount++;
        pdAtt = int'(attemptCount);
      end
    end
  end

  task automatic push(input logic [1:0] op, input logic [7:0] dat);
    if (expN < 64) expArr[expN] = {op, dat};
    expN++;
  endtask

  // expected command stream from the requirements
  task automatic buildExp(input vec_t v);
    int eff, a;
    logic fail;
    expN = 0;
    eff  = (v.maxAtt == 0) ? 1 : int'(v.maxAtt);
    fail = (int'(v.nacks) >= eff);
    a    = fail ? eff : int'(v.nacks) + 1;
    for (int k = 0; k < a; k++) begin
      push(2'd0, 8'h00);
      push(2'd1, {v.dev, 1'b0});
      if (k < a - 1 && v.sb) push(2'd2, 8'h00);
    end
    if (fail) push(2'd2, 8'h00);
    else begin
      push(2'd1, v.addr[15:8]);
      push(2'd1, v.addr[7:0]);
      if (v.rd) begin
        push(2'd3, 8'h00);
        push(2'd1, {v.dev, 1'b1});
      end
    end
  endtask

  initial begin
    int bad, waitC;
    vec_t v;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !cmdValid, "R1 idle after reset", busy, 0);
    chk(!pollDone && !timeoutErr, "R1 flags after reset", {pollDone, timeoutErr}, 0);
    chk(attemptCount == 0, "R1 count after reset", attemptCount, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      lat = int'(v.lat);
      nackLeft = int'(v.nacks);
      logN = 0;
      pdCount = 0;
      prevOp = 2'd2;
      devAddr = v.dev; byteAddr = v.addr; readNext = v.rd;
      maxAttempts = v.maxAtt; stopBetween = v.sb;
      startPoll = 1'b1;
      @(negedge clk);
      startPoll = 1'b0;
      // R8: disturb inputs and pulse start while busy
      devAddr = ~v.dev; byteAddr = ~v.addr; readNext = ~v.rd;
      maxAttempts = 8'd200; stopBetween = ~v.sb;
      @(negedge clk);
      startPoll = 1'b1;
      @(negedge clk);
      startPoll = 1'b0;
      waitC = 0;
      while (busy && waitC < 2000) begin
        @(negedge clk);
        waitC++;
      end
      repeat (4) @(negedge clk);
      buildExp(v);
      chk(!busy, "R5 R6 idle at end", busy, 0);
      chk(timeoutErr == v.expErr, "R7 timeout flag", timeoutErr, v.expErr);
      chk(attemptCount == v.expAtt, "R4 R7 attempt count", attemptCount, v.expAtt);
      chk(pdCount == (v.expErr ? 0 : 1), "R4 R7 pollDone pulses", pdCount, v.expErr ? 0 : 1);
      if (!v.expErr) chk(pdAtt == int'(v.expAtt), "R4 count at pollDone", pdAtt, v.expAtt);
      bad = -1;
      for (int k = 0; k < expN; k++)
        if (bad < 0 && (k >= logN || logArr[k] != expArr[k])) bad = k;
      chk(logN == expN && bad < 0, "R2 R3 R5 R6 R8 command stream",
          (bad < 0) ? logN : int'(logArr[bad]), (bad < 0) ? expN : int'(expArr[bad]));
    end

    chk(stableErr == 0, "R9 command held until done", stableErr, 0);

    // R7: flag stays after a failed run, clears on next start
    lat = 0; nackLeft = 5; logN = 0; prevOp = 2'd2;
    devAddr = 7'h10; byteAddr = 16'h0102; readNext = 1'b0;
    maxAttempts = 8'd2; stopBetween = 1'b0;
    startPoll = 1'b1; @(negedge clk); startPoll = 1'b0;
    repeat (20) @(negedge clk);
    chk(timeoutErr, "R7 flag held after run", timeoutErr, 1);
    nackLeft = 0;
    startPoll = 1'b1; @(negedge clk); startPoll = 1'b0;
    @(negedge clk);
    chk(!timeoutErr, "R7 flag cleared by start", timeoutErr, 0);
    repeat (20) @(negedge clk);

    // R1: reset in the middle of a run
    lat = 3; nackLeft = 50; maxAttempts = 8'd60;
    startPoll = 1'b1; @(negedge clk); startPoll = 1'b0;
    repeat (15) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!busy && !cmdValid && attemptCount == 0, "R1 mid-run reset",
        {busy, cmdValid, attemptCount}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!busy && !cmdValid, "R1 stays idle after reset", {busy, cmdValid}, 0);

    finishRun();
  end

endmodule